// File: doc/BRIEF.md
# I2C Master Abort Cause Tracker

This block keeps a record of why an I2C master transfer was abandoned. It sits next to the master's bit-level engine and watches one-cycle event strobes from it: the outcome of each address byte, data byte, General Call, High Speed master code and START byte, together with a High Speed request strobe and a strobe that marks the command queued after a General Call. It also reads three configuration levels: restart enable, the special-command select, and the select that chooses between a General Call and a START byte.

Each abort cause owns one bit of a 10-bit status word. The bits are sticky and are cleared together by a single clear strobe. Any newly recorded cause raises a one-cycle abort pulse that tells the engine to flush and go idle. Nine of the causes are events. The tenth, a START byte requested while restart is disabled, is a level condition. A clear drops that bit for one cycle only, and the bit keeps coming back until the configuration that causes it is changed.

All outputs are registered. A cause presented in cycle N is visible on `flags_o` and `abort_o` after the following rising clock edge.

Top module: `i2c_abort_tracker`

## Requirements
- R1: After reset, `flags_o` is 0 and `abort_o` is 0. Asserting `rst_n` low while flags are set returns both outputs to 0.
- R2: The first-address-byte strobe with `ack_i`=0 sets bit 0 when `addr10_i`=0 and bit 1 when `addr10_i`=1. The second-address-byte strobe with `ack_i`=0 sets bit 2, but only when `addr10_i`=1. An acknowledged address byte sets nothing.
- R3: The data-byte strobe with `ack_i`=0 sets bit 3. An acknowledged data byte sets nothing.
- R4: The General Call strobe with `ack_i`=0 sets bit 4. The command strobe with `cmd_read_i`=1 sets bit 5 while General Call mode is selected (`special_i`=1, `sbyte_sel_i`=0). A write command, or a read command outside that mode, sets nothing.
- R5: The master-code strobe with `ack_i`=1 sets bit 6. The START-byte strobe with `ack_i`=1 sets bit 7. The same strobes with `ack_i`=0 set nothing.
- R6: The High Speed request strobe sets bit 8 when `restart_en_i`=0. It has no effect when `restart_en_i`=1.
- R7: Bit 9 sets one cycle after the level cause `restart_en_i`=0, `special_i`=1, `sbyte_sel_i`=1 is present. No bit 9 is set if any one of the three inputs differs.
- R8: While the bit 9 cause persists, a clear makes bit 9 read 0 for exactly one cycle, after which it reads 1 again. Once the cause is removed, a clear leaves bit 9 at 0.
- R9: Bits 0 to 8 are sticky until `clr_i`. `clr_i` clears all bits in one cycle. An event that arrives in the same cycle as the clear still sets its bit.
- R10: `abort_o` is high for exactly one cycle after each cycle in which any of bits 0 to 8 is set by an event, even if the bit was already 1, and after each 0-to-1 change of bit 9. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear strobe for all flags |
| addr10_i | input | 1 | 10-bit addressing selected |
| restart_en_i | input | 1 | Repeated START permitted |
| special_i | input | 1 | Special command (General Call or START byte) selected |
| sbyte_sel_i | input | 1 | 1 selects START byte, 0 selects General Call |
| ack_i | input | 1 | Acknowledge result for the strobes in this cycle |
| addr1_done_i | input | 1 | First (or only) address byte finished |
| addr2_done_i | input | 1 | Second 10-bit address byte finished |
| data_done_i | input | 1 | Data byte finished |
| gcall_done_i | input | 1 | General Call byte finished |
| hs_code_done_i | input | 1 | High Speed master code finished |
| sbyte_done_i | input | 1 | START byte finished |
| hs_req_i | input | 1 | High Speed transfer requested |
| cmd_valid_i | input | 1 | Command queued behind a special command |
| cmd_read_i | input | 1 | Queued command is a read |
| flags_o | output | 10 | Sticky abort cause bits |
| abort_o | output | 1 | One-cycle abort pulse |

## Verification
The bench targets the bit 9 recovery sequence. It clears while the cause is held, where a design that kept the bit low or never dropped it would fail. It then clears after the cause is removed, where a design that still re-set the bit would fail. A clear that coincides with a new event checks that the event is not lost, and a repeat of an event on a bit that is already set checks that the abort pulse still fires. The second address byte in 7-bit mode, acknowledged bytes, and write or non-General-Call commands check that a decoder which sets bits too freely is caught.

// File: rtl/i2c_abort_pkg.sv
package i2c_abort_pkg;

    localparam int unsigned NUM_CAUSES = 10;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;

    typedef enum int unsigned {
        C_ADDR7_NACK   = 0,
        C_ADDR10A_NACK = 1,
        C_ADDR10B_NACK = 2,
        C_DATA_NACK    = 3,
        C_GCALL_NACK   = 4,
        C_GCALL_READ   = 5,
        C_HSCODE_ACK   = 6,
        C_SBYTE_ACK    = 7,
        C_HS_NORESTART = 8,
        C_SB_NORESTART = 9
    } cause_idx_e;

    // Causes that are held by configuration rather than raised by an event.
    localparam cause_vec_t LEVEL_CAUSES = cause_vec_t'(1) << C_SB_NORESTART;

    typedef struct packed {
        logic ack;
        logic addr1_done;
        logic addr2_done;
        logic data_done;
        logic gcall_done;
        logic hs_code_done;
        logic sbyte_done;
        logic hs_req;
        logic cmd_valid;
        logic cmd_read;
    } engine_ev_t;

    typedef struct packed {
        logic addr10;
        logic restart_en;
        logic special;
        logic sbyte_sel;
    } cause_cfg_t;

endpackage

// File: rtl/i2c_abort_decode.sv
module i2c_abort_decode
    import i2c_abort_pkg::*;
(
    input  engine_ev_t ev_i,
    input  cause_cfg_t cfg_i,
    output cause_vec_t set_o
);

    logic gcall_mode;
    logic sbyte_mode;
    logic nack;

    always_comb begin
        gcall_mode = cfg_i.special & ~cfg_i.sbyte_sel;
        sbyte_mode = cfg_i.special &  cfg_i.sbyte_sel;
        nack       = ~ev_i.ack;

        set_o                 = '0;
        set_o[C_ADDR7_NACK]   = ev_i.addr1_done & nack & ~cfg_i.addr10;
        set_o[C_ADDR10A_NACK] = ev_i.addr1_done & nack &  cfg_i.addr10;
        set_o[C_ADDR10B_NACK] = ev_i.addr2_done & nack &  cfg_i.addr10;
        set_o[C_DATA_NACK]    = ev_i.data_done  & nack;
        set_o[C_GCALL_NACK]   = ev_i.gcall_done & nack;
        set_o[C_GCALL_READ]   = ev_i.cmd_valid  & ev_i.cmd_read & gcall_mode;
        set_o[C_HSCODE_ACK]   = ev_i.hs_code_done & ev_i.ack;
        set_o[C_SBYTE_ACK]    = ev_i.sbyte_done   & ev_i.ack;
        set_o[C_HS_NORESTART] = ev_i.hs_req & ~cfg_i.restart_en;
        set_o[C_SB_NORESTART] = sbyte_mode & ~cfg_i.restart_en;
    end

endmodule

// File: rtl/i2c_abort_flags.sv
module i2c_abort_flags
    import i2c_abort_pkg::*;
#(
    parameter int unsigned  WIDTH      = NUM_CAUSES,
    parameter logic [WIDTH-1:0] LEVEL_MASK = LEVEL_CAUSES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] set_i,
    output logic [WIDTH-1:0] flags_o,
    output logic             abort_o
);

    typedef struct packed {
        logic [WIDTH-1:0] flags;
        logic             abort;
    } state_t;

    state_t state_d, state_q;

    logic [WIDTH-1:0] bit_next;
    logic [WIDTH-1:0] bit_new;

    // Per-bit next value: event bits let a same-cycle set beat the clear,
    // level bits are always dropped by a clear and re-raised by their cause.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            assign bit_next[i] = clr_i ? 1'b0 : (state_q.flags[i] | set_i[i]);
            assign bit_new[i]  = ~clr_i & set_i[i] & ~state_q.flags[i];
        end else begin : g_event
            assign bit_next[i] = (state_q.flags[i] & ~clr_i) | set_i[i];
            assign bit_new[i]  = set_i[i];
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.flags = bit_next;
        state_d.abort = |bit_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;
    assign abort_o = state_q.abort;

endmodule

// File: rtl/i2c_abort_tracker.sv
module i2c_abort_tracker
    import i2c_abort_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  addr10_i,
    input  logic                  restart_en_i,
    input  logic                  special_i,
    input  logic                  sbyte_sel_i,
    input  logic                  ack_i,
    input  logic                  addr1_done_i,
    input  logic                  addr2_done_i,
    input  logic                  data_done_i,
    input  logic                  gcall_done_i,
    input  logic                  hs_code_done_i,
    input  logic                  sbyte_done_i,
    input  logic                  hs_req_i,
    input  logic                  cmd_valid_i,
    input  logic                  cmd_read_i,
    output logic [NUM_CAUSES-1:0] flags_o,
    output logic                  abort_o
);

    engine_ev_t ev;
    cause_cfg_t cfg;
    cause_vec_t cause_set;

    always_comb begin
        ev.ack          = ack_i;
        ev.addr1_done   = addr1_done_i;
        ev.addr2_done   = addr2_done_i;
        ev.data_done    = data_done_i;
        ev.gcall_done   = gcall_done_i;
        ev.hs_code_done = hs_code_done_i;
        ev.sbyte_done   = sbyte_done_i;
        ev.hs_req       = hs_req_i;
        ev.cmd_valid    = cmd_valid_i;
        ev.cmd_read     = cmd_read_i;

        cfg.addr10      = addr10_i;
        cfg.restart_en  = restart_en_i;
        cfg.special     = special_i;
        cfg.sbyte_sel   = sbyte_sel_i;
    end

    i2c_abort_decode u_decode (
        .ev_i  (ev),
        .cfg_i (cfg),
        .set_o (cause_set)
    );

    i2c_abort_flags #(
        .WIDTH      (NUM_CAUSES),
        .LEVEL_MASK (LEVEL_CAUSES)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .set_i   (cause_set),
        .flags_o (flags_o),
        .abort_o (abort_o)
    );

endmodule

// File: rtl/i2c_abort_tracker_chk.sv
module i2c_abort_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_i,
    input logic       addr10_i,
    input logic       restart_en_i,
    input logic       special_i,
    input logic       sbyte_sel_i,
    input logic       ack_i,
    input logic       addr1_done_i,
    input logic       addr2_done_i,
    input logic       data_done_i,
    input logic       gcall_done_i,
    input logic       hs_code_done_i,
    input logic       sbyte_done_i,
    input logic       hs_req_i,
    input logic       cmd_valid_i,
    input logic       cmd_read_i,
    input logic [9:0] flags_o,
    input logic       abort_o
);

    AST_ADDR7_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr1_done_i && !ack_i && !addr10_i) |=> (flags_o[0] && abort_o)); // R2

    AST_ADDR2_7BIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr2_done_i && !addr10_i && !flags_o[2]) |=> !flags_o[2]); // R2

    AST_DATA_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done_i && !ack_i) |=> (flags_o[3] && abort_o)); // R3

    AST_GCALL_CAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((gcall_done_i && !ack_i) ||
         (cmd_valid_i && cmd_read_i && special_i && !sbyte_sel_i))
        |=> (flags_o[4] || flags_o[5])); // R4

    AST_ILLEGAL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_code_done_i || sbyte_done_i) && ack_i) |=> (flags_o[6] || flags_o[7])); // R5

    AST_HS_NORESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req_i && !restart_en_i) |=> flags_o[8]); // R6

    AST_SB_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_en_i && special_i && sbyte_sel_i && !clr_i) |=> flags_o[9]); // R7

    AST_SB_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flags_o[9]); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o[8:0] & $past(flags_o[8:0])) == $past(flags_o[8:0]))); // R9

    AST_ABORT_ONE_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !addr1_done_i && !addr2_done_i && !data_done_i && !gcall_done_i &&
         !hs_code_done_i && !sbyte_done_i && !hs_req_i && !cmd_valid_i && !clr_i &&
         $stable(flags_o[9]) && (restart_en_i || !special_i || !sbyte_sel_i))
        |=> !abort_o); // R10

endmodule

bind i2c_abort_tracker i2c_abort_tracker_chk u_chk (.*);

// File: tb/i2c_abort_tracker_tb.sv
module i2c_abort_tracker_tb;

    // Stimulus word bit positions
    localparam logic [14:0] S_ACK  = 15'd1 << 0;
    localparam logic [14:0] S_A1   = 15'd1 << 1;
    localparam logic [14:0] S_A2   = 15'd1 << 2;
    localparam logic [14:0] S_DATA = 15'd1 << 3;
    localparam logic [14:0] S_GC   = 15'd1 << 4;
    localparam logic [14:0] S_HSC  = 15'd1 << 5;
    localparam logic [14:0] S_SB   = 15'd1 << 6;
    localparam logic [14:0] S_HSR  = 15'd1 << 7;
    localparam logic [14:0] S_CMD  = 15'd1 << 8;
    localparam logic [14:0] S_RD   = 15'd1 << 9;
    localparam logic [14:0] S_CLR  = 15'd1 << 10;
    localparam logic [14:0] S_M10  = 15'd1 << 11;
    localparam logic [14:0] S_REN  = 15'd1 << 12;
    localparam logic [14:0] S_SPC  = 15'd1 << 13;
    localparam logic [14:0] S_SEL  = 15'd1 << 14;

    typedef struct {
        logic [9:0] flags;
        logic       abort;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [14:0] stim = S_REN;
    logic [9:0] flags;
    logic abort;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    i2c_abort_tracker u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (stim[10]),
        .addr10_i       (stim[11]),
        .restart_en_i   (stim[12]),
        .special_i      (stim[13]),
        .sbyte_sel_i    (stim[14]),
        .ack_i          (stim[0]),
        .addr1_done_i   (stim[1]),
        .addr2_done_i   (stim[2]),
        .data_done_i    (stim[3]),
        .gcall_done_i   (stim[4]),
        .hs_code_done_i (stim[5]),
        .sbyte_done_i   (stim[6]),
        .hs_req_i       (stim[7]),
        .cmd_valid_i    (stim[8]),
        .cmd_read_i     (stim[9]),
        .flags_o        (flags),
        .abort_o        (abort)
    );

    task automatic check(input logic [9:0] ef, input logic ea, input string tag);
        n_tests++;
        if (flags !== ef || abort !== ea) begin
            n_fail++;
            $display("FAIL %s: flags=%h abort=%b expected flags=%h abort=%b",
                     tag, flags, abort, ef, ea);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic cyc(input logic [14:0] s, input logic [9:0] ef, input logic ea,
                       input string tag);
        exp_t e;
        @(negedge clk);
        stim = s;
        e.flags = ef;
        e.abort = ea;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares once the registered outputs have settled.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.flags, e.abort, e.tag);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check(10'h000, 1'b0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        cyc(S_REN,                  10'h000, 0, "R1 idle after reset");
        cyc(S_REN|S_A1,             10'h001, 1, "R2 7-bit address nack");
        cyc(S_REN,                  10'h001, 0, "R10 pulse lasts one cycle, R9 sticky");
        cyc(S_REN|S_CLR,            10'h000, 0, "R9 clear");
        cyc(S_REN|S_M10|S_A1,       10'h002, 1, "R2 10-bit first byte nack");
        cyc(S_REN|S_M10|S_A2,       10'h006, 1, "R2 10-bit second byte nack");
        cyc(S_REN|S_A2,             10'h006, 0, "R2 second byte ignored in 7-bit");
        cyc(S_REN|S_M10|S_A1|S_ACK, 10'h006, 0, "R2 acked address no effect");
        cyc(S_REN|S_CLR,            10'h000, 0, "R9 clear all");
        cyc(S_REN|S_DATA,           10'h008, 1, "R3 data nack");
        cyc(S_REN|S_DATA,           10'h008, 1, "R10 pulse on repeat event");
        cyc(S_REN|S_DATA|S_ACK,     10'h008, 0, "R3 acked data no effect");
        cyc(S_REN|S_CLR,            10'h000, 0, "R9 clear");
        cyc(S_REN|S_GC,             10'h010, 1, "R4 general call nack");
        cyc(S_REN|S_SPC|S_CMD|S_RD, 10'h030, 1, "R4 read after general call");
        cyc(S_REN|S_SPC|S_CMD,      10'h030, 0, "R4 write after general call ignored");
        cyc(S_REN|S_CLR,            10'h000, 0, "R9 clear");
        cyc(S_REN|S_CMD|S_RD,       10'h000, 0, "R4 read without special ignored");
        cyc(S_REN|S_SPC|S_SEL|S_CMD|S_RD, 10'h000, 0, "R4 read in START byte mode ignored");
        cyc(S_REN|S_GC|S_ACK,       10'h000, 0, "R4 acked general call no effect");
        cyc(S_REN|S_HSC|S_ACK,      10'h040, 1, "R5 master code acked");
        cyc(S_REN|S_HSC,            10'h040, 0, "R5 master code nack no effect");
        cyc(S_REN|S_SB|S_ACK,       10'h0C0, 1, "R5 START byte acked");
        cyc(S_REN|S_SB,             10'h0C0, 0, "R5 START byte nack no effect");
        cyc(S_REN|S_CLR,            10'h000, 0, "R9 clear");
        cyc(S_REN|S_HSR,            10'h000, 0, "R6 HS request with restart enabled");
        cyc(S_HSR,                  10'h100, 1, "R6 HS request with restart disabled");
        cyc(S_REN|S_CLR|S_A1,       10'h001, 1, "R9 set beats coincident clear");
        cyc(S_REN|S_CLR,            10'h000, 0, "R9 clear");
        cyc(S_SEL,                  10'h000, 0, "R7 no cause without special");
        cyc(S_REN|S_SPC|S_SEL,      10'h000, 0, "R7 no cause with restart enabled");
        cyc(S_SPC|S_SEL,            10'h200, 1, "R7 START byte without restart");
        cyc(S_SPC|S_SEL,            10'h200, 0, "R10 no pulse while held");
        cyc(S_SPC|S_SEL|S_CLR,      10'h000, 0, "R8 clear drops bit 9");
        cyc(S_SPC|S_SEL,            10'h200, 1, "R8 bit 9 reasserts");
        cyc(S_SPC,                  10'h200, 0, "R8 cause removed, still sticky");
        cyc(S_SPC|S_CLR,            10'h000, 0, "R8 clear after fix");
        cyc(S_SPC,                  10'h000, 0, "R8 bit 9 stays clear");
        cyc(S_HSR,                  10'h100, 1, "R6 set before reset");
        cyc(S_REN,                  10'h100, 0, "R9 sticky before reset");

        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check(10'h000, 1'b0, "R1 reset clears set flags");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule